// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit with Dot-Product Mode

This block is the arithmetic core of a DSP datapath for filters such as FIR and IIR stages. On each cycle with input valid it takes two 18-bit operands and a 2-bit mode. It forms one product from them: a full signed 18x18 product, an unsigned product of the low 17 bits, or a two-term cross product of the 9-bit operand halves. It then folds that product into a 44-bit accumulator. Each product is added to the running sum or subtracted from it. Instead of that, it can replace the sum, which passes the product through.

The operands and controls go into an input register stage. The multiply and the accumulate update take place in the second stage, whose output is the accumulator register. A result therefore appears two clock cycles after its input. A caller streams samples with `in_vld` high and starts a new sum by raising `clr_acc` on the first sample. The caller reads `acc_out` whenever `out_vld` is high.

Top module: `mac_dot_unit`

## Requirements
- R1: With mode 2'b00, and also with mode 2'b11, the product is `op_a` times `op_b`, both taken as 18-bit two's-complement numbers.
- R2: With mode 2'b01, the product is `op_a[16:0]` times `op_b[16:0]`, both taken as unsigned. Bit 17 of each operand has no effect.
- R3: With mode 2'b10, the product is (`op_a[8:0]` x `op_b[17:9]` + `op_a[17:9]` x `op_b[8:0]`) shifted left by 9. The upper halves are signed and the lower halves unsigned, so a loaded dot product always has `acc_out[8:0]` equal to zero.
- R4: A valid input with `clr_acc`=0 and `sub_sel`=0 adds the product to the accumulator.
- R5: A valid input with `clr_acc`=0 and `sub_sel`=1 subtracts the product from the accumulator.
- R6: A valid input with `clr_acc`=1 loads the accumulator with the product, or with its negation when `sub_sel`=1. The old sum is discarded.
- R7: While `in_vld` is low, the operands, mode, `clr_acc` and `sub_sel` have no effect, and the accumulator holds its value.
- R8: `out_vld` is high exactly two rising edges after the edge that samples `in_vld` high, and `acc_out` shows the updated sum in that same cycle.
- R9: The accumulator wraps modulo 2^44 in both directions, with no saturation.
- R10: A synchronous reset `rst` clears the accumulator and `out_vld`, and discards any sample still in the pipeline.
- R11: Valid inputs on consecutive cycles are each accumulated in order, one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Sample valid |
| mode | input | 2 | Product select: 00 signed, 01 unsigned, 10 dot, 11 signed |
| clr_acc | input | 1 | Load instead of accumulate |
| sub_sel | input | 1 | Subtract (or negate on load) |
| op_a | input | 18 | Operand A |
| op_b | input | 18 | Operand B |
| acc_out | output | 44 | Accumulator value |
| out_vld | output | 1 | Accumulator updated this cycle |

## Verification
Every result is due at the second rising edge after the edge that samples its `in_vld`. The driver stamps each expected sum with the cycle number at which it is due, and the monitor samples on the falling edge. In that cycle the monitor requires `out_vld` high and the matching sum on `acc_out`. In any other cycle `out_vld` must be low. Idle cycles carry junk on the controls, and the sum that follows them shows whether the held accumulator was disturbed.

// File: rtl/mac_pkg.sv
package mac_pkg;

    // Product selection; the code values are part of the port contract.
    typedef enum logic [1:0] {
        MODE_SGN = 2'b00,
        MODE_UNS = 2'b01,
        MODE_DOT = 2'b10,
        MODE_RSV = 2'b11
    } mac_mode_e;

    typedef struct packed {
        mac_mode_e mode;
        logic      clr;
        logic      sub;
    } mac_ctl_t;

endpackage

// File: rtl/mac_in_stage.sv
module mac_in_stage
    import mac_pkg::*;
#(
    parameter int OPW = 18
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_vld,
    input  mac_ctl_t       ctl_in,
    input  logic [OPW-1:0] a_in,
    input  logic [OPW-1:0] b_in,
    output logic           vld_q,
    output mac_ctl_t       ctl_q,
    output logic [OPW-1:0] a_q,
    output logic [OPW-1:0] b_q
);

    // Operands are loaded only with a valid sample, so they stay still while the unit is idle.
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            ctl_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
        end else begin
            vld_q <= in_vld;
            if (in_vld) begin
                ctl_q <= ctl_in;
                a_q   <= a_in;
                b_q   <= b_in;
            end
        end
    end

endmodule

// File: rtl/mac_product.sv
module mac_product
    import mac_pkg::*;
#(
    parameter int OPW  = 18,
    parameter int ACCW = 44
) (
    input  logic [OPW-1:0]  a,
    input  logic [OPW-1:0]  b,
    input  mac_mode_e       mode,
    output logic [ACCW-1:0] prod
);

    localparam int PW   = 2 * OPW;         // signed product width
    localparam int UW   = 2 * (OPW - 1);   // unsigned product width
    localparam int HALF = OPW / 2;         // low half width, also dot shift
    localparam int HI   = OPW - HALF;      // high half width
    localparam int DW   = HALF + HI + 2;   // dot sum width with headroom

    // Full signed product, operands sign-extended to the result width.
    logic [PW-1:0] sgn_a, sgn_b, p_sgn;
    assign sgn_a = {{OPW{a[OPW-1]}}, a};
    assign sgn_b = {{OPW{b[OPW-1]}}, b};
    assign p_sgn = sgn_a * sgn_b;

    // Unsigned product of the low OPW-1 bits; the top bit never enters.
    logic [UW-1:0] uns_a, uns_b, p_uns;
    assign uns_a = {{(OPW-1){1'b0}}, a[OPW-2:0]};
    assign uns_b = {{(OPW-1){1'b0}}, b[OPW-2:0]};
    assign p_uns = uns_a * uns_b;

    // Dot mode: low halves are unsigned, high halves signed.
    logic [DW-1:0] a_lo, a_hi, b_lo, b_hi, x_lohi, x_hilo, dsum;
    assign a_lo   = {{(DW-HALF){1'b0}}, a[HALF-1:0]};
    assign b_lo   = {{(DW-HALF){1'b0}}, b[HALF-1:0]};
    assign a_hi   = {{(DW-HI){a[OPW-1]}}, a[OPW-1:HALF]};
    assign b_hi   = {{(DW-HI){b[OPW-1]}}, b[OPW-1:HALF]};
    assign x_lohi = a_lo * b_hi;
    assign x_hilo = a_hi * b_lo;
    assign dsum   = x_lohi + x_hilo;

    logic [ACCW-1:0] p_sgn_x, p_uns_x, p_dot_x;
    assign p_sgn_x = {{(ACCW-PW){p_sgn[PW-1]}}, p_sgn};
    assign p_uns_x = {{(ACCW-UW){1'b0}}, p_uns};
    assign p_dot_x = {{(ACCW-DW-HALF){dsum[DW-1]}}, dsum, {HALF{1'b0}}};

    always_comb begin
        unique case (mode)
            MODE_SGN, MODE_RSV: prod = p_sgn_x;
            MODE_UNS:           prod = p_uns_x;
            MODE_DOT:           prod = p_dot_x;
            default:            prod = p_sgn_x;
        endcase
    end

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
    parameter int ACCW = 44
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            vld,
    input  logic            clr,
    input  logic            sub,
    input  logic [ACCW-1:0] prod,
    output logic [ACCW-1:0] acc,
    output logic            acc_vld
);

    logic [ACCW-1:0] base, acc_nxt;

    // One adder serves load and accumulate: a load starts from a zero base.
    always_comb begin
        base    = clr ? '0 : acc;
        acc_nxt = sub ? (base - prod) : (base + prod);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            acc_vld <= 1'b0;
        end else begin
            acc_vld <= vld;
            if (vld) begin
                acc <= acc_nxt;
            end
        end
    end

endmodule

// File: rtl/mac_dot_unit.sv
module mac_dot_unit
    import mac_pkg::*;
#(
    parameter int OPW  = 18,
    parameter int ACCW = 44
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_vld,
    input  logic [1:0]      mode,
    input  logic            clr_acc,
    input  logic            sub_sel,
    input  logic [OPW-1:0]  op_a,
    input  logic [OPW-1:0]  op_b,
    output logic [ACCW-1:0] acc_out,
    output logic            out_vld
);

    mac_ctl_t        ctl_in, ctl_q;
    logic            vld_q;
    logic [OPW-1:0]  a_q, b_q;
    logic [ACCW-1:0] prod;

    assign ctl_in = '{mode: mac_mode_e'(mode), clr: clr_acc, sub: sub_sel};

    mac_in_stage #(.OPW(OPW)) u_in (
        .clk    (clk),
        .rst    (rst),
        .in_vld (in_vld),
        .ctl_in (ctl_in),
        .a_in   (op_a),
        .b_in   (op_b),
        .vld_q  (vld_q),
        .ctl_q  (ctl_q),
        .a_q    (a_q),
        .b_q    (b_q)
    );

    mac_product #(.OPW(OPW), .ACCW(ACCW)) u_prod (
        .a    (a_q),
        .b    (b_q),
        .mode (ctl_q.mode),
        .prod (prod)
    );

    mac_accum #(.ACCW(ACCW)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .vld     (vld_q),
        .clr     (ctl_q.clr),
        .sub     (ctl_q.sub),
        .prod    (prod),
        .acc     (acc_out),
        .acc_vld (out_vld)
    );

endmodule

// File: rtl/mac_dot_unit_chk.sv
module mac_dot_unit_chk #(
    parameter int OPW  = 18,
    parameter int ACCW = 44
) (
    input logic            clk,
    input logic            rst,
    input logic            in_vld,
    input logic [1:0]      mode,
    input logic            clr_acc,
    input logic [ACCW-1:0] acc_out,
    input logic            out_vld
);

    localparam int HALF = OPW / 2;

    // Counts the edges since reset was released, saturating at 3.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                since_rst <= 2'd0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (acc_out == '0 && !out_vld));

    // R8
    vld_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2) |-> (out_vld == $past(in_vld, 2)));

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 1 && !out_vld) |-> $stable(acc_out));

    // R3
    dot_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2 && $past(in_vld && clr_acc && mode == 2'b10, 2))
        |-> (acc_out[HALF-1:0] == '0));

endmodule

bind mac_dot_unit mac_dot_unit_chk #(.OPW(OPW), .ACCW(ACCW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .mode    (mode),
    .clr_acc (clr_acc),
    .acc_out (acc_out),
    .out_vld (out_vld)
);

// File: tb/mac_dot_unit_test.sv
module mac_dot_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        clr_acc = 1'b0;
    logic        sub_sel = 1'b0;
    logic [17:0] op_a = '0;
    logic [17:0] op_b = '0;
    logic [43:0] acc_out;
    logic        out_vld;

    always #10 clk = ~clk;   // 50 MHz

    mac_dot_unit uut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .mode(mode),
        .clr_acc(clr_acc), .sub_sel(sub_sel), .op_a(op_a), .op_b(op_b),
        .acc_out(acc_out), .out_vld(out_vld)
    );

    typedef struct {
        int          due;
        logic [43:0] val;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          cyc = 0;
    int          total = 0;
    int          bad = 0;
    bit          ended = 0;
    logic [43:0] model = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag,
                         input logic [43:0] act, input logic [43:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [43:0] ref_prod(input logic [17:0] a,
                                             input logic [17:0] b,
                                             input logic [1:0] m);
        longint r, ah, al, bh, bl;
        if (m == 2'b01) begin
            r = longint'(a[16:0]) * longint'(b[16:0]);
        end else if (m == 2'b10) begin
            ah = longint'($signed(a[17:9]));
            bh = longint'($signed(b[17:9]));
            al = longint'(a[8:0]);
            bl = longint'(b[8:0]);
            r  = (al * bh + ah * bl) * 512;
        end else begin
            r = longint'($signed(a)) * longint'($signed(b));
        end
        return r[43:0];
    endfunction

    task automatic issue(input logic [17:0] a, input logic [17:0] b,
                         input logic [1:0] m, input bit clr, input bit sub,
                         input string tag);
        logic [43:0] p;
        exp_t e;
        @(negedge clk);
        in_vld = 1'b1; op_a = a; op_b = b; mode = m; clr_acc = clr; sub_sel = sub;
        p = ref_prod(a, b, m);
        if (clr) model = sub ? (44'd0 - p) : p;
        else     model = sub ? (model - p) : (model + p);
        e.due = cyc + 2; e.val = model; e.tag = tag;
        sb.push_back(e);
    endtask

    // Idle cycles with junk on every control (R7).
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0; clr_acc = 1'b1; sub_sel = 1'b1; mode = 2'b10;
            op_a = 18'h2AAAA; op_b = 18'h15555;
        end
    endtask

    task automatic drain();
        idle(1);
        while (sb.size() > 0) idle(1);
        idle(1);
    endtask

    // Monitor: each expected item must arrive in its due cycle, nothing else.
    always @(negedge clk) begin
        if (!rst && !ended) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                check(out_vld && acc_out == e.val, e.tag, acc_out, e.val);
            end else if (out_vld) begin
                check(1'b0, "R8 unexpected out_vld", acc_out, 44'd0);
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(acc_out == 0 && !out_vld, "R10 reset state", acc_out, 44'd0);
        rst = 1'b0;

        issue(18'h3FFFD, 18'd5, 2'b00, 1, 0, "R6 R1 load signed -3*5");
        issue(18'h20000, 18'h20000, 2'b00, 0, 0, "R1 R4 add -2^17*-2^17");
        issue(18'd100, 18'h3FFF9, 2'b11, 0, 0, "R1 mode 11 signed");
        issue(18'h3FFFF, 18'h20001, 2'b01, 0, 1, "R2 R5 unsigned subtract, bit17 ignored");
        drain();

        idle(3);
        issue(18'd1, 18'd1, 2'b00, 0, 0, "R7 sum held over idle junk");
        drain();

        issue({9'h1FF, 9'h1FF}, {9'h100, 9'h0FF}, 2'b10, 1, 0, "R3 dot load mixed signs");
        issue({9'h0FF, 9'h001}, {9'h1FE, 9'h100}, 2'b10, 0, 0, "R3 R4 dot add");
        issue({9'h100, 9'h1FF}, {9'h100, 9'h1FF}, 2'b10, 1, 1, "R6 R3 dot load negated");
        drain();

        issue(18'd7, 18'd9, 2'b00, 1, 0, "R11 burst 1");
        issue(18'h1FFFF, 18'h1FFFF, 2'b01, 0, 0, "R11 burst 2");
        issue(18'h3FFFF, 18'd3, 2'b00, 0, 1, "R11 burst 3");
        issue({9'h0A5, 9'h15A}, {9'h1C3, 9'h03C}, 2'b10, 0, 0, "R11 burst 4");
        issue(18'h12345, 18'h0ABCD, 2'b11, 0, 1, "R11 burst 5");
        issue(18'h00010, 18'h00020, 2'b01, 0, 0, "R11 burst 6");
        drain();

        issue(18'h20000, 18'h20000, 2'b00, 1, 1, "R9 R6 load -2^34");
        issue(18'h20000, 18'h20000, 2'b00, 0, 0, "R9 add back to zero");
        issue(18'h20000, 18'h20000, 2'b00, 0, 0, "R9 add 2^34");
        issue(18'd0, 18'd0, 2'b00, 1, 0, "R6 load zero");
        issue(18'd1, 18'd1, 2'b00, 0, 1, "R9 wrap below zero");
        drain();

        // Reset with a sample in flight: it must not appear.
        issue(18'd50, 18'd50, 2'b00, 0, 0, "R10 dropped");
        @(negedge clk);
        in_vld = 1'b0;
        rst = 1'b1;
        sb.delete();
        model = '0;
        repeat (2) @(negedge clk);
        check(acc_out == 0 && !out_vld, "R10 reset clears sum", acc_out, 44'd0);
        rst = 1'b0;
        issue(18'd2, 18'd3, 2'b00, 0, 0, "R10 accumulate from zero after reset");
        drain();

        finish_run();
    end

endmodule